// File: doc/BRIEF.md
# DMA Channel Status and Source-Address Unit

This block keeps the per-channel state that sits between software and a DMA channel engine. It has a status word with four sticky event flags (timeout, bus error, reload, count-to-zero) that software clears by writing 1, a read-only interrupt-pending bit, and a read-only channel-enabled bit. It also has the 32-bit source-address register together with its reload register. The channel engine reports events on single-cycle strobes. Software programs the enable, increment, reload and width settings and reads back the status word and the address.

The source address advances by the transfer width on each bus beat while the channel runs and increment is selected. When a count-to-zero event arrives with reload selected, the address is restored from the reload register. A bus abort raises the bus-error flag and turns the channel off. The same register drives the configuration enable output and status bit 0, so both fall in the same cycle. Software may rewrite the source address only while the channel is off. For peripheral transfers, the address presented to the request path is forced to zero.

Top module: `dma_chan_stat_src`

## Requirements
- R1: The status word `st_rdata` is 8 bits wide. Bit 6 is timeout, bit 4 is bus error, bit 3 is reload, bit 2 is count-to-zero, bit 1 is interrupt pending and bit 0 is channel enabled. Bits 7 and 5 always read 0. After reset every status bit, `cfg_en`, the source address and the reload register are 0.
- R2: A strobe on `ev_timeout`, `ev_bus_err` or `ev_ctz` sets the matching flag one cycle later. The flag then stays set until a cycle with `st_wr` high and a 1 in that flag's bit position of `st_wdata`. Zeros in `st_wdata` leave flags unchanged, and so do writes to bits 0, 1, 5 and 7.
- R3: When a hardware set and a software write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R4: A cycle with `cfg_wr` high loads `cfg_wdata_en` into the channel enable. A cycle with `ev_bus_err` high clears the enable instead, even if `cfg_wr` is high in the same cycle. The enable drives `cfg_en` and status bit 0, so both change together.
- R5: `ipend` (and status bit 1) is high when at least one flag is set with its enable high in `irq_en`. The mapping is bit 0 = count-to-zero, bit 1 = reload, bit 2 = bus error, bit 3 = timeout.
- R6: A `src_wr` loads `src_wdata` into the source address only while the channel is disabled. While the channel is enabled, the write is ignored.
- R7: While the channel is enabled and `cfg_srcinc` is 1, each `ev_beat` adds to the source address, wrapping modulo 2^32. The step is 1 for `cfg_width` 00, 2 for 01, and 4 for 10 or 11. When `cfg_srcinc` is 0, or the channel is disabled, beats leave the address unchanged.
- R8: A cycle with `ev_ctz` high, `cfg_rlden` high and the channel enabled loads the reload register into the source address and sets the reload flag. This takes priority over a beat in the same cycle. Otherwise the reload flag is not set.
- R9: `req_addr` equals the source address when `cfg_periph` is 0, and is 0 when `cfg_periph` is 1.
- R10: A `rld_wr` loads `rld_wdata` into the reload register in any state. A reload in the same cycle uses the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_timeout | input | 1 | Channel timeout strobe |
| ev_bus_err | input | 1 | Bus abort strobe |
| ev_ctz | input | 1 | Count-to-zero strobe |
| ev_beat | input | 1 | Completed bus beat strobe |
| cfg_srcinc | input | 1 | Source increment select |
| cfg_rlden | input | 1 | Reload select |
| cfg_width | input | 2 | Transfer width code |
| cfg_periph | input | 1 | Peripheral transfer select |
| cfg_wr | input | 1 | Enable write strobe |
| cfg_wdata_en | input | 1 | Enable write value |
| irq_en | input | 4 | Per-flag interrupt enables |
| st_wr | input | 1 | Status write-1-to-clear strobe |
| st_wdata | input | 8 | Status write data |
| src_wr | input | 1 | Source address write strobe |
| src_wdata | input | 32 | Source address write data |
| rld_wr | input | 1 | Reload register write strobe |
| rld_wdata | input | 32 | Reload register write data |
| st_rdata | output | 8 | Status word |
| cfg_en | output | 1 | Channel configuration enable |
| ipend | output | 1 | Interrupt pending |
| src_addr | output | 32 | Source address register |
| req_addr | output | 32 | Address presented to the request path |

## Verification
The hardest cases to reach from the ports involve coincident events while the channel is running:
- A reload and a beat in the same cycle.
- A bus abort together with a software enable write.
- A flag set together with its write-1 clear.

Directed sequences enable the channel first and then fire these combinations, including a reload that coincides with a write to the reload register. A long random phase follows, with low-rate bus aborts and frequent enable writes, so that the channel keeps toggling between running and stopped while beats, reloads and address writes arrive.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    DW_BYTE = 2'b00,
    DW_HALF = 2'b01,
    DW_WORD = 2'b10,
    DW_WIDE = 2'b11
  } dw_e;

  localparam int unsigned NFLAG   = 4;
  localparam int unsigned FL_CTZ  = 0;
  localparam int unsigned FL_RLD  = 1;
  localparam int unsigned FL_BERR = 2;
  localparam int unsigned FL_TMO  = 3;

  function automatic logic [2:0] dw_bytes(input dw_e w);
    case (w)
      DW_BYTE: dw_bytes = 3'd1;
      DW_HALF: dw_bytes = 3'd2;
      default: dw_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dcs_flag_bank.sv
module dcs_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ien_i,
  output logic [N-1:0] flags_o,
  output logic         ipend_o
);
  logic [N-1:0] flags_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_d, flag_we;

    always_comb begin
      flag_we = set_i[g] | clr_i[g];
      flag_d  = set_i[g] | (flags_q[g] & ~clr_i[g]);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)      flags_q[g] <= 1'b0;
      else if (flag_we) flags_q[g] <= flag_d;
    end

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      set_i[g] |=> flags_q[g]);

    // R2
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flags_q[g]);
  end

  assign flags_o = flags_q;
  assign ipend_o = |(flags_q & ien_i);
endmodule

// File: rtl/dcs_chan_enable.sv
module dcs_chan_enable (
  input  logic clk,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic berr_i,
  output logic en_o
);
  logic en_q, en_d, en_we;

  always_comb begin
    en_we = wr_i | berr_i;
    en_d  = berr_i ? 1'b0 : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    en_q <= 1'b0;
    else if (en_we) en_q <= en_d;
  end

  assign en_o = en_q;

  // R4
  berr_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    berr_i |=> !en_q);
endmodule

// File: rtl/dcs_src_addr.sv
module dcs_src_addr
  import dcs_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          beat_i,
  input  logic          inc_i,
  input  logic          rlden_i,
  input  logic          ctz_i,
  input  dw_e           width_i,
  input  logic          periph_i,
  input  logic          src_wr_i,
  input  logic [AW-1:0] src_wdata_i,
  input  logic          rld_wr_i,
  input  logic [AW-1:0] rld_wdata_i,
  output logic          reload_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] req_o
);
  localparam int unsigned SW = 3;

  logic [AW-1:0] src_q, src_d, rld_q;
  logic          src_we, do_step, do_load;
  logic [SW-1:0] step_b;

  always_comb begin
    reload_o = en_i & ctz_i & rlden_i;
    do_step  = en_i & beat_i & inc_i;
    do_load  = ~en_i & src_wr_i;
    step_b   = dw_bytes(width_i);
    src_we   = reload_o | do_step | do_load;
    if (reload_o)     src_d = rld_q;
    else if (do_step) src_d = src_q + {{(AW-SW){1'b0}}, step_b};
    else              src_d = src_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     src_q <= '0;
    else if (src_we) src_q <= src_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       rld_q <= '0;
    else if (rld_wr_i) rld_q <= rld_wdata_i;
  end

  assign src_o = src_q;
  assign req_o = periph_i ? '0 : src_q;

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && ctz_i && rlden_i) |=> (src_q == $past(rld_q)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && !(beat_i && inc_i) && !(ctz_i && rlden_i)) |=> $stable(src_q));

  // R7
  step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && beat_i && inc_i && !(ctz_i && rlden_i)) |=>
      (src_q == $past(src_q) + {{(AW-SW){1'b0}}, $past(step_b)}));
endmodule

// File: rtl/dma_chan_stat_src.sv
module dma_chan_stat_src
  import dcs_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_timeout,
  input  logic          ev_bus_err,
  input  logic          ev_ctz,
  input  logic          ev_beat,
  input  logic          cfg_srcinc,
  input  logic          cfg_rlden,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_periph,
  input  logic          cfg_wr,
  input  logic          cfg_wdata_en,
  input  logic [3:0]    irq_en,
  input  logic          st_wr,
  input  logic [7:0]    st_wdata,
  input  logic          src_wr,
  input  logic [AW-1:0] src_wdata,
  input  logic          rld_wr,
  input  logic [AW-1:0] rld_wdata,
  output logic [7:0]    st_rdata,
  output logic          cfg_en,
  output logic          ipend,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] req_addr
);
  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic             en, reload_ev;
  logic [NFLAG-1:0] fl_set, fl_clr, flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  dcs_chan_enable u_en (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .wr_i    (cfg_wr),
    .wdata_i (cfg_wdata_en),
    .berr_i  (ev_bus_err),
    .en_o    (en)
  );

  dcs_src_addr #(.AW(AW)) u_src (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .en_i        (en),
    .beat_i      (ev_beat),
    .inc_i       (cfg_srcinc),
    .rlden_i     (cfg_rlden),
    .ctz_i       (ev_ctz),
    .width_i     (dw_e'(cfg_width)),
    .periph_i    (cfg_periph),
    .src_wr_i    (src_wr),
    .src_wdata_i (src_wdata),
    .rld_wr_i    (rld_wr),
    .rld_wdata_i (rld_wdata),
    .reload_o    (reload_ev),
    .src_o       (src_addr),
    .req_o       (req_addr)
  );

  always_comb begin
    fl_set          = '0;
    fl_set[FL_CTZ]  = ev_ctz;
    fl_set[FL_RLD]  = reload_ev;
    fl_set[FL_BERR] = ev_bus_err;
    fl_set[FL_TMO]  = ev_timeout;
    fl_clr          = '0;
    fl_clr[FL_CTZ]  = st_wr & st_wdata[2];
    fl_clr[FL_RLD]  = st_wr & st_wdata[3];
    fl_clr[FL_BERR] = st_wr & st_wdata[4];
    fl_clr[FL_TMO]  = st_wr & st_wdata[6];
  end

  dcs_flag_bank #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .set_i   (fl_set),
    .clr_i   (fl_clr),
    .ien_i   (irq_en),
    .flags_o (flags),
    .ipend_o (ipend)
  );

  assign cfg_en   = en;
  assign st_rdata = {1'b0, flags[FL_TMO], 1'b0, flags[FL_BERR],
                     flags[FL_RLD], flags[FL_CTZ], ipend, en};

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_rdata[7] == 1'b0) && (st_rdata[5] == 1'b0));
endmodule

// File: tb/dma_chan_stat_src_bench.sv
module dma_chan_stat_src_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_timeout, ev_bus_err, ev_ctz, ev_beat;
  logic        cfg_srcinc, cfg_rlden, cfg_periph, cfg_wr, cfg_wdata_en;
  logic [1:0]  cfg_width;
  logic [3:0]  irq_en;
  logic        st_wr, src_wr, rld_wr;
  logic [7:0]  st_wdata;
  logic [31:0] src_wdata, rld_wdata;
  logic [7:0]  st_rdata;
  logic        cfg_en, ipend;
  logic [31:0] src_addr, req_addr;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  bit          m_to, m_be, m_rl, m_cz, m_en;
  bit [31:0]   m_src, m_rld;
  string       tag_fl, tag_src;

  always #(PERIOD/2) clk = ~clk;

  dma_chan_stat_src u_dma_chan_stat_src (
    .clk(clk), .rst_n(rst_n),
    .ev_timeout(ev_timeout), .ev_bus_err(ev_bus_err), .ev_ctz(ev_ctz), .ev_beat(ev_beat),
    .cfg_srcinc(cfg_srcinc), .cfg_rlden(cfg_rlden), .cfg_width(cfg_width),
    .cfg_periph(cfg_periph), .cfg_wr(cfg_wr), .cfg_wdata_en(cfg_wdata_en),
    .irq_en(irq_en), .st_wr(st_wr), .st_wdata(st_wdata),
    .src_wr(src_wr), .src_wdata(src_wdata), .rld_wr(rld_wr), .rld_wdata(rld_wdata),
    .st_rdata(st_rdata), .cfg_en(cfg_en), .ipend(ipend),
    .src_addr(src_addr), .req_addr(req_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    ev_timeout = 0; ev_bus_err = 0; ev_ctz = 0; ev_beat = 0;
    cfg_wr = 0; cfg_wdata_en = 0; st_wr = 0; st_wdata = 0;
    src_wr = 0; src_wdata = 0; rld_wr = 0; rld_wdata = 0;
  endtask

  task automatic compare();
    bit ip;
    ip = (m_cz & irq_en[0]) | (m_rl & irq_en[1]) | (m_be & irq_en[2]) | (m_to & irq_en[3]);
    chk("R1 reserved bits", {30'd0, st_rdata[7], st_rdata[5]}, 32'd0);
    chk({tag_fl, " timeout flag"}, st_rdata[6], m_to);
    chk({tag_fl, " bus-error flag"}, st_rdata[4], m_be);
    chk({tag_fl, " ctz flag"}, st_rdata[2], m_cz);
    chk("R8 reload flag", st_rdata[3], m_rl);
    chk("R4 enable status", st_rdata[0], m_en);
    chk("R4 cfg_en", cfg_en, m_en);
    chk("R5 ipend", ipend, ip);
    chk("R5 status ipend", st_rdata[1], ip);
    chk(tag_src, src_addr, m_src);
    chk("R9 req_addr", req_addr, cfg_periph ? 32'd0 : m_src);
  endtask

  // apply the model for the current inputs, clock once, compare
  task automatic tick();
    bit [31:0] step;
    bit c_cz, c_rl, c_be, c_to, rl_ev;
    step  = (cfg_width == 2'b00) ? 1 : (cfg_width == 2'b01) ? 2 : 4;
    rl_ev = m_en && ev_ctz && cfg_rlden;
    c_cz = st_wr && st_wdata[2];
    c_rl = st_wr && st_wdata[3];
    c_be = st_wr && st_wdata[4];
    c_to = st_wr && st_wdata[6];
    tag_fl = ((c_cz && ev_ctz) || (c_be && ev_bus_err) || (c_to && ev_timeout)) ? "R3" : "R2";
    if (rl_ev) tag_src = rld_wr ? "R10 src after reload" : "R8 src after reload";
    else if (m_en && src_wr) tag_src = "R6 src write while enabled";
    else tag_src = "R7 src_addr";
    m_cz = ev_ctz | (m_cz & !c_cz);
    m_rl = rl_ev | (m_rl & !c_rl);
    m_be = ev_bus_err | (m_be & !c_be);
    m_to = ev_timeout | (m_to & !c_to);
    if (rl_ev) m_src = m_rld;
    else if (m_en && ev_beat && cfg_srcinc) m_src = m_src + step;
    else if (!m_en && src_wr) m_src = src_wdata;
    if (rld_wr) m_rld = rld_wdata;
    if (ev_bus_err) m_en = 0;
    else if (cfg_wr) m_en = cfg_wdata_en;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin : watchdog
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    idle();
    cfg_srcinc = 0; cfg_rlden = 0; cfg_width = 2'b00; cfg_periph = 0; irq_en = 4'hF;
    tag_fl = "R1"; tag_src = "R1 src reset";
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare();                        // R1 reset state
    rst_n = 1;
    repeat (3) tick();                // synchronizer release

    // R6 write while disabled, R10 reload register
    src_wr = 1; src_wdata = 32'hFFFF_FFFA; rld_wr = 1; rld_wdata = 32'h0000_1000; tick();
    idle(); cfg_wr = 1; cfg_wdata_en = 1; tick();
    idle();
    // R7 stepping through each width, with wrap
    cfg_srcinc = 1;
    for (int w = 0; w < 4; w++) begin
      cfg_width = w[1:0]; ev_beat = 1; tick();
    end
    cfg_srcinc = 0; ev_beat = 1; tick();        // R7 hold
    idle(); src_wr = 1; src_wdata = 32'h1234_5678; tick(); // R6 ignored
    // R8 reload beats a simultaneous step; R10 same-cycle write
    idle(); cfg_srcinc = 1; cfg_rlden = 1; ev_ctz = 1; ev_beat = 1;
    rld_wr = 1; rld_wdata = 32'hAAAA_0000; tick();
    idle(); ev_ctz = 1; tick();
    // R3 set and clear together
    idle(); ev_timeout = 1; ev_ctz = 1; st_wr = 1; st_wdata = 8'hFF; tick();
    idle(); st_wr = 1; st_wdata = 8'h23; tick();     // R2 bits 0,1,5 ignored
    idle(); irq_en = 4'h2; tick(); irq_en = 4'h0; tick(); // R5
    // R4 bus error overrides enable write
    idle(); ev_bus_err = 1; cfg_wr = 1; cfg_wdata_en = 1; tick();
    idle(); cfg_rlden = 1; ev_ctz = 1; tick();        // no reload while disabled
    idle(); cfg_periph = 1; tick(); cfg_periph = 0;   // R9

    for (int i = 0; i < 6000; i++) begin
      idle();
      ev_timeout = ($urandom_range(0, 99) < 5);
      ev_bus_err = ($urandom_range(0, 99) < 2);
      ev_ctz     = ($urandom_range(0, 99) < 8);
      ev_beat    = ($urandom_range(0, 99) < 50);
      cfg_srcinc = ($urandom_range(0, 99) < 80);
      cfg_rlden  = $urandom_range(0, 1);
      cfg_width  = 2'($urandom_range(0, 3));
      cfg_periph = ($urandom_range(0, 99) < 30);
      cfg_wr     = ($urandom_range(0, 99) < 8);
      cfg_wdata_en = ($urandom_range(0, 99) < 80);
      irq_en     = 4'($urandom_range(0, 15));
      st_wr      = ($urandom_range(0, 99) < 15);
      st_wdata   = 8'($urandom);
      src_wr     = ($urandom_range(0, 99) < 10);
      src_wdata  = $urandom;
      rld_wr     = ($urandom_range(0, 99) < 5);
      rld_wdata  = $urandom;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule